// File: doc/BRIEF.md
# Two-Level ALU Control and Datapath

This block is the execute-stage arithmetic unit of a simple integer core, with the decoder that chooses its operation. Main control sends a coarse 2-bit operation class. The instruction's 6-bit function field is used only when that class marks an arithmetic (register-register) instruction. A second-level decoder turns the class and the function field into a 3-bit ALU operation code. A 32-bit ALU then carries out that operation on two operands and returns the result and a zero flag.

Loads and stores use the class that forces addition, so the ALU forms a memory address. Branch-on-equal uses the class that forces subtraction, so equal operands show up as a zero flag of 1. Every path is combinational. The result is valid in the same cycle as the inputs.

Top module: `alu_two_level`

## Requirements
- R1: `alu_op_o` carries only these codes: 3'b000 AND, 3'b001 OR, 3'b010 add, 3'b110 subtract, 3'b111 set-on-less-than. Bit 2 of a code means "invert operand B and carry in 1".
- R2: Operation class 2'b00 (memory access) selects add for every function field value.
- R3: Operation class 2'b01 (branch-equal) selects subtract for every function field value. In that class `zero_o` is 1 exactly when `a_i` equals `b_i`.
- R4: Under operation class 2'b10, the function field picks the operation: 6'b100000 add, 6'b100010 subtract, 6'b100100 AND, 6'b100101 OR, 6'b101010 set-on-less-than.
- R5: Under class 2'b10, any function field value not listed in R4 selects add. Class 2'b11 also selects add, whatever the function field holds.
- R6: AND and OR give the bitwise AND and bitwise OR of `a_i` and `b_i`.
- R7: Add gives `a_i + b_i` modulo 2^32. Subtract gives `a_i - b_i` modulo 2^32. Any carry out or overflow is dropped, and no trap is raised.
- R8: Set-on-less-than gives 32'd1 when `a_i < b_i` as signed two's-complement numbers, and 32'd0 otherwise. The answer is correct even when the internal subtraction overflows.
- R9: `zero_o` is 1 exactly when all 32 bits of `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class_i | input | 2 | Operation class from main control |
| funct_i | input | 6 | Function field of the instruction |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| alu_op_o | output | 3 | Decoded ALU operation code |
| result_o | output | 32 | ALU result |
| zero_o | output | 1 | Result-is-zero flag |

## Verification
The assertions check every input change for the following:
- The decoder emits only legal codes.
- The memory and branch classes force their fixed operations.
- Subtraction reports equality on the zero flag.
- Set-on-less-than returns only 0 or 1.
- Adding zero returns the first operand.

Only the bench's scenarios can show the rest:
- The full function-field mapping.
- The fallback to add.
- The exact wraparound values.
- Set-on-less-than around signed overflow, for example the most negative value compared with the most positive.

// File: rtl/alu_ctrl_pkg.sv
package alu_ctrl_pkg;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned CLASS_W = 2;
  localparam int unsigned FUNCT_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_ARITH  = 2'b10,
    CLS_RSVD   = 2'b11
  } op_class_e;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

  // bit 2 of the op code drives B inversion and carry-in
  localparam int unsigned OP_BINV_BIT = 2;
endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_ctrl_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output alu_op_e            alu_op_o
);
  alu_op_e funct_op;

  always_comb begin
    unique case (funct_i)
      FN_ADD:  funct_op = OP_ADD;
      FN_SUB:  funct_op = OP_SUB;
      FN_AND:  funct_op = OP_AND;
      FN_OR:   funct_op = OP_OR;
      FN_SLT:  funct_op = OP_SLT;
      default: funct_op = OP_ADD;
    endcase
  end

  always_comb begin
    unique case (op_class_e'(op_class_i))
      CLS_MEM:    alu_op_o = OP_ADD;
      CLS_BRANCH: alu_op_o = OP_SUB;
      CLS_ARITH:  alu_op_o = funct_op;
      default:    alu_op_o = OP_ADD;
    endcase
  end

  always_comb begin
    AST_LEGAL_OP: assert (alu_op_o inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT}); // R1
    AST_MEM_ADD: assert (op_class_i != CLS_MEM || alu_op_o == OP_ADD); // R2
    AST_BRANCH_SUB: assert (op_class_i != CLS_BRANCH || alu_op_o == OP_SUB); // R3
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              b_inv_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              less_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   raw;
  logic              ovf;

  assign b_eff = b_inv_i ? ~b_i : b_i;
  assign raw   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, b_inv_i};
  assign sum_o = raw[MSB:0];
  // signed overflow: equal input signs, differing result sign
  assign ovf    = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  assign less_o = sum_o[MSB] ^ ovf;

  always_comb begin
    AST_ADD_IDENTITY: assert (b_inv_i || b_i != '0 || sum_o == a_i); // R7
    AST_SUB_SELF_ZERO: assert (!b_inv_i || a_i != b_i || sum_o == '0); // R7
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
  end
endmodule

// File: rtl/alu_two_level.sv
module alu_two_level
  import alu_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        op_class_i,
  input  logic [5:0]        funct_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [2:0]        alu_op_o,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] sum, and_v, or_v;
  logic              less;

  alu_op_decoder u_dec (
    .op_class_i (op_class_i),
    .funct_i    (funct_i),
    .alu_op_o   (op)
  );

  alu_adder #(.DATA_W(DATA_W)) u_add (
    .a_i     (a_i),
    .b_i     (b_i),
    .b_inv_i (op[OP_BINV_BIT]),
    .sum_o   (sum),
    .less_o  (less)
  );

  alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_v),
    .or_o  (or_v)
  );

  always_comb begin
    unique case (op)
      OP_AND:  result_o = and_v;
      OP_OR:   result_o = or_v;
      OP_SLT:  result_o = {{(DATA_W-1){1'b0}}, less};
      default: result_o = sum;
    endcase
  end

  assign zero_o   = ~|result_o;
  assign alu_op_o = op;

  always_comb begin
    AST_SLT_BINARY: assert (op != OP_SLT || result_o[DATA_W-1:1] == '0); // R8
    AST_SUB_EQ_ZERO: assert (op != OP_SUB || zero_o == (a_i == b_i)); // R3
    AST_ZERO_ON_EQ_BRANCH: assert (op_class_i != CLS_BRANCH || a_i != b_i || zero_o); // R9
  end
endmodule

// File: tb/tb_alu_two_level.sv
module tb_alu_two_level;
  localparam int unsigned W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [1:0]   op_class;
  logic [5:0]   funct;
  logic [W-1:0] a, b;
  logic [2:0]   alu_op;
  logic [W-1:0] result;
  logic         zero;

  int n_cmp = 0;
  int n_bad = 0;

  alu_two_level #(.DATA_W(W)) dut (
    .op_class_i (op_class),
    .funct_i    (funct),
    .a_i        (a),
    .b_i        (b),
    .alu_op_o   (alu_op),
    .result_o   (result),
    .zero_o     (zero)
  );

  function automatic logic [2:0] ref_op(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 3'b010;
    if (c == 2'b01) return 3'b110;
    if (c == 2'b10) begin
      if (f == 6'h20) return 3'b010;
      if (f == 6'h22) return 3'b110;
      if (f == 6'h24) return 3'b000;
      if (f == 6'h25) return 3'b001;
      if (f == 6'h2a) return 3'b111;
    end
    return 3'b010;
  endfunction

  function automatic logic [W-1:0] ref_res(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    if (o == 3'b000) return x & y;
    if (o == 3'b001) return x | y;
    if (o == 3'b110) return x - y;
    if (o == 3'b111) return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
    return x + y;
  endfunction

  task automatic apply(input logic [1:0] c, input logic [5:0] f, input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    op_class = c; funct = f; a = x; b = y;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] eo, input logic [W-1:0] er, input logic ez);
    n_cmp++;
    if (alu_op !== eo || result !== er || zero !== ez) begin
      n_bad++;
      $display("FAIL %s: op=%b res=%h z=%b expected op=%b res=%h z=%b",
               req, alu_op, result, zero, eo, er, ez);
    end
  endtask

  typedef struct packed {
    logic [1:0]   cls;
    logic [5:0]   fn;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 6'h24, 32'h0000_1000, 32'h0000_0064, 4'd2}, // R2 funct ignored
    '{2'b00, 6'h2a, 32'hffff_fffc, 32'h0000_0004, 4'd2}, // R2
    '{2'b01, 6'h25, 32'h1234_5678, 32'h1234_5678, 4'd3}, // R3 equal
    '{2'b01, 6'h20, 32'h1234_5678, 32'h1234_5679, 4'd3}, // R3 unequal
    '{2'b10, 6'h20, 32'h7fff_ffff, 32'h0000_0001, 4'd4}, // R4 add
    '{2'b10, 6'h22, 32'h0000_0003, 32'h0000_0005, 4'd4}, // R4 sub
    '{2'b10, 6'h24, 32'hf0f0_a5a5, 32'h0ff0_ffff, 4'd6}, // R6 and
    '{2'b10, 6'h25, 32'hf0f0_0000, 32'h0000_5a5a, 4'd6}, // R6 or
    '{2'b10, 6'h2a, 32'hffff_ffff, 32'h0000_0000, 4'd8}, // R8 -1 < 0
    '{2'b10, 6'h21, 32'h0000_0010, 32'h0000_0020, 4'd5}, // R5 unknown funct
    '{2'b10, 6'h00, 32'h0000_0001, 32'h0000_0002, 4'd5}, // R5
    '{2'b11, 6'h22, 32'h0000_0007, 32'h0000_0009, 4'd5}, // R5 class 11
    '{2'b11, 6'h24, 32'hffff_ffff, 32'h0000_0001, 4'd9}, // R9 wrap to zero
    '{2'b10, 6'h24, 32'haaaa_aaaa, 32'h5555_5555, 4'd9}  // R9 and to zero
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    op_class = '0; funct = '0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle", 3'b010, 32'h0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]   eo;
      logic [W-1:0] er;
      apply(VEC[i].cls, VEC[i].fn, VEC[i].x, VEC[i].y);
      eo = ref_op(VEC[i].cls, VEC[i].fn);
      er = ref_res(eo, VEC[i].x, VEC[i].y);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), eo, er, er == '0);
    end

    // R1 R4 R5: full function-field sweep under each class
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 64; f++) begin
        logic [2:0]   eo;
        logic [W-1:0] er;
        apply(c[1:0], f[5:0], 32'h8000_0001, 32'h7fff_fffe);
        eo = ref_op(c[1:0], f[5:0]);
        er = ref_res(eo, 32'h8000_0001, 32'h7fff_fffe);
        check("R1 sweep", eo, er, er == '0);
      end
    end

    // R8: signed compare with subtraction overflow
    apply(2'b10, 6'h2a, 32'h8000_0000, 32'h7fff_ffff);
    check("R8 minneg<maxpos", 3'b111, 32'd1, 1'b0);
    apply(2'b10, 6'h2a, 32'h7fff_ffff, 32'h8000_0000);
    check("R8 maxpos>minneg", 3'b111, 32'd0, 1'b1);
    apply(2'b10, 6'h2a, 32'h0000_0005, 32'h0000_0005);
    check("R8 equal", 3'b111, 32'd0, 1'b1);
    // R7: wraparound
    apply(2'b10, 6'h22, 32'h0000_0000, 32'h0000_0001);
    check("R7 sub wrap", 3'b110, 32'hffff_ffff, 1'b0);
    apply(2'b00, 6'h00, 32'h8000_0000, 32'h8000_0000);
    check("R7 add wrap", 3'b010, 32'h0, 1'b1);
    // R3: branch equality on zero flag
    apply(2'b01, 6'h2a, 32'hdead_beef, 32'hdead_beef);
    check("R3 beq taken", 3'b110, 32'h0, 1'b1);
    apply(2'b01, 6'h2a, 32'h8000_0000, 32'h0000_0000);
    check("R3 beq not taken", 3'b110, 32'h8000_0000, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule